// File: doc/BRIEF.md
# Variable-Width Byte-Row Rotator

This block performs the row-rotation step of an AES-style block cipher round on a state of four byte rows. The number of columns is 4, 6 or 8, and a mode input selects it on each beat. A direction bit picks either the forward transform, which rotates each row left, or its inverse, which rotates each row right. The rotation amount of each row depends on the row index and on the column count.

The state bus is sized for the widest mode. A beat is accepted when `in_valid` is high. Its result appears on the output one clock later, qualified by `out_valid`. Beats may arrive on consecutive cycles, and each beat may carry its own mode and direction. The other round transformations sit in neighbouring blocks.

Top module: `shift_rows_var`

## Requirements
- R1: `in_mode` selects the column count: 2'b00 gives 4 columns, 2'b01 gives 6, 2'b10 gives 8, and the spare code 2'b11 behaves exactly as 4 columns.
- R2: The state is packed column-major. Byte index k covers bits [255-8k : 248-8k] and holds row k%4 of column k/4, so byte 0 (row 0, column 0) is the most significant byte.
- R3: With `in_inv` = 0 each row rotates left: output row r, column c takes input row r, column (c+s) mod N, where N is the column count and s is the row's offset.
- R4: In the 4- and 6-column modes, the offset of row r is r. Rows 0, 1, 2 and 3 therefore move by 0, 1, 2 and 3.
- R5: In the 8-column mode, the offsets of rows 0, 1, 2 and 3 are 0, 1, 3 and 4.
- R6: With `in_inv` = 1 each row rotates right by the same offsets: output row r, column c takes input row r, column (c−s) mod N.
- R7: Output columns at index N and above are zero in the 4- and 6-column modes.
- R8: A beat presented with `in_valid` high at a rising edge produces its result on `out_state`, with `out_valid` high, after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R9: While `in_valid` is low, `out_state` holds its last value, whatever `in_state`, `in_mode` and `in_inv` do.
- R10: A forward pass followed by an inverse pass in the same mode returns the original state, with the unused columns zeroed.
- R11: During reset and after it, until the first beat, `out_valid` is 0 and `out_state` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat qualifier |
| in_mode | input | 2 | Column-count select (R1) |
| in_inv | input | 1 | 0 = forward (left), 1 = inverse (right) |
| in_state | input | 256 | Input state, column-major |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_state | output | 256 | Rotated state |

## Verification
The registered stage can capture a new beat in the same cycle that it presents the previous result. The mode and the direction can also change between two such adjacent beats. The bench provokes both by streaming beats back to back while alternating the mode and the direction on each beat. It checks every result in the cycle it appears against an independent column-index model, so if any state from the earlier beat leaked into the later one, the mismatch would show.

// File: rtl/srow_pkg.sv
package srow_pkg;
  localparam int SR_ROWS = 4;

  typedef enum logic [1:0] {
    MODE_C4  = 2'b00,
    MODE_C6  = 2'b01,
    MODE_C8  = 2'b10,
    MODE_RSV = 2'b11
  } srow_mode_e;

  // column count for a mode code; the spare code falls back to 4 columns
  function automatic int unsigned mode_cols(input logic [1:0] m);
    case (srow_mode_e'(m))
      MODE_C6: return 6;
      MODE_C8: return 8;
      default: return 4;
    endcase
  endfunction

  // per-row rotation; the widest mode skips offset 2
  function automatic int unsigned row_offset(input int unsigned ncols,
                                             input int unsigned row);
    if (ncols == 8 && row >= 2) return row + 1;
    return row;
  endfunction
endpackage

// File: rtl/srow_rst_sync.sv
module srow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/srow_mode_dec.sv
module srow_mode_dec
  import srow_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [1:0]                      mode,
  output logic [CNT_W-1:0]                ncols,
  output logic [SR_ROWS-1:0][CNT_W-1:0]   shift
);
  int unsigned cols;

  always_comb begin
    cols  = mode_cols(mode);
    ncols = CNT_W'(cols);
  end

  for (genvar r = 0; r < SR_ROWS; r++) begin : g_off
    always_comb shift[r] = CNT_W'(row_offset(cols, r));
  end
endmodule

// File: rtl/srow_row_rot.sv
module srow_row_rot #(
  parameter int MAX_COLS = 8,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 4
) (
  input  logic [MAX_COLS-1:0][BYTE_W-1:0] row_in,
  input  logic [CNT_W-1:0]                ncols,
  input  logic [CNT_W-1:0]                amt,
  input  logic                            inv,
  output logic [MAX_COLS-1:0][BYTE_W-1:0] row_out
);
  localparam int IDX_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
  localparam int SUM_W = CNT_W + 1;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    logic [SUM_W-1:0] src;
    logic [IDX_W-1:0] sel;

    always_comb begin
      // amt < ncols and c < ncols, so one wrap subtraction suffices
      if (inv) src = SUM_W'(c) + SUM_W'(ncols) - SUM_W'(amt);
      else     src = SUM_W'(c) + SUM_W'(amt);
      if (src >= SUM_W'(ncols)) src = src - SUM_W'(ncols);
      sel = src[IDX_W-1:0];
      if (CNT_W'(c) < ncols) row_out[c] = row_in[sel];
      else                   row_out[c] = '0;
    end
  end
endmodule

// File: rtl/srow_pipe.sv
module srow_pipe #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= q_nxt;
      vld <= en;
    end
  end
endmodule

// File: rtl/shift_rows_var.sv
module shift_rows_var
  import srow_pkg::*;
#(
  parameter int MAX_COLS = 8,
  parameter int BYTE_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [1:0]                           in_mode,
  input  logic                                 in_inv,
  input  logic [SR_ROWS*MAX_COLS*BYTE_W-1:0]   in_state,
  output logic                                 out_valid,
  output logic [SR_ROWS*MAX_COLS*BYTE_W-1:0]   out_state
);
  localparam int ST_W  = SR_ROWS * MAX_COLS * BYTE_W;
  localparam int CNT_W = $clog2(MAX_COLS + 1);

  logic                                       rst_sync_n;
  logic [CNT_W-1:0]                           ncols;
  logic [SR_ROWS-1:0][CNT_W-1:0]              shift;
  logic [SR_ROWS-1:0][MAX_COLS-1:0][BYTE_W-1:0] rows_in;
  logic [SR_ROWS-1:0][MAX_COLS-1:0][BYTE_W-1:0] rows_out;
  logic [ST_W-1:0]                            rotated;

  srow_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srow_mode_dec #(.CNT_W(CNT_W)) u_dec (
    .mode  (in_mode),
    .ncols (ncols),
    .shift (shift)
  );

  for (genvar r = 0; r < SR_ROWS; r++) begin : g_row
    for (genvar c = 0; c < MAX_COLS; c++) begin : g_byte
      localparam int K = c * SR_ROWS + r;
      assign rows_in[r][c] = in_state[ST_W-1-K*BYTE_W -: BYTE_W];
      assign rotated[ST_W-1-K*BYTE_W -: BYTE_W] = rows_out[r][c];
    end

    srow_row_rot #(
      .MAX_COLS (MAX_COLS),
      .BYTE_W   (BYTE_W),
      .CNT_W    (CNT_W)
    ) u_rot (
      .row_in  (rows_in[r]),
      .ncols   (ncols),
      .amt     (shift[r]),
      .inv     (in_inv),
      .row_out (rows_out[r])
    );
  end

  srow_pipe #(.W(ST_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (in_valid),
    .d     (rotated),
    .q     (out_state),
    .vld   (out_valid)
  );
endmodule

// File: rtl/srow_chk.sv
module srow_chk #(
  parameter int MAX_COLS = 8,
  parameter int BYTE_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [1:0]                     in_mode,
  input logic                           in_inv,
  input logic [4*MAX_COLS*BYTE_W-1:0]   in_state,
  input logic                           out_valid,
  input logic [4*MAX_COLS*BYTE_W-1:0]   out_state
);
  localparam int W   = 4 * MAX_COLS * BYTE_W;
  localparam int LOW = (MAX_COLS - 4) * 4 * BYTE_W;

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid == $past(in_valid)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !in_valid |=> $stable(out_state)); // R9

  AST_ROW0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_state[W-1 -: BYTE_W] == $past(in_state[W-1 -: BYTE_W])); // R4

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00) |=> out_state[LOW-1:0] == '0); // R7

  AST_WIDE_ROW3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10) |=>
      out_state[W-1-3*BYTE_W -: BYTE_W] == $past(in_state[W-1-19*BYTE_W -: BYTE_W])); // R5

  AST_INV_ROW1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00 && in_inv) |=>
      out_state[W-1-1*BYTE_W -: BYTE_W] == $past(in_state[W-1-13*BYTE_W -: BYTE_W])); // R6
endmodule

bind shift_rows_var srow_chk #(
  .MAX_COLS (MAX_COLS),
  .BYTE_W   (BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_inv    (in_inv),
  .in_state  (in_state),
  .out_valid (out_valid),
  .out_state (out_state)
);

// File: tb/shift_rows_var_tb.sv
`timescale 1ns/1ps
module shift_rows_var_tb;
  localparam int SW = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_mode;
  logic          in_inv;
  logic [SW-1:0] in_state;
  logic          out_valid;
  logic [SW-1:0] out_state;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  shift_rows_var u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_inv    (in_inv),
    .in_state  (in_state),
    .out_valid (out_valid),
    .out_state (out_state)
  );

  function automatic int ncols_of(input logic [1:0] m);
    if (m == 2'b01) return 6;
    if (m == 2'b10) return 8;
    return 4;
  endfunction

  function automatic logic [SW-1:0] model(input logic [SW-1:0] x,
                                          input logic [1:0] m, input logic inv);
    logic [SW-1:0] y;
    int n;
    n = ncols_of(m);
    y = '0;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < n; c++) begin
        int s;
        int src;
        s   = (n == 8 && r >= 2) ? r + 1 : r;
        src = inv ? (c - s + n) % n : (c + s) % n;
        y[SW-1-8*(c*4+r) -: 8] = x[SW-1-8*(src*4+r) -: 8];
      end
    end
    return y;
  endfunction

  function automatic logic [SW-1:0] keep_cols(input logic [SW-1:0] x, input logic [1:0] m);
    logic [SW-1:0] y;
    y = '0;
    for (int k = 0; k < 4*ncols_of(m); k++) y[SW-1-8*k -: 8] = x[SW-1-8*k -: 8];
    return y;
  endfunction

  function automatic logic [SW-1:0] pattern(input logic [7:0] seed, input logic [7:0] step);
    logic [SW-1:0] p;
    for (int k = 0; k < 32; k++) p[SW-1-8*k -: 8] = seed + step * 8'(k);
    return p;
  endfunction

  task automatic check(input string req, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // present one beat at a negedge, return what the output shows one edge later
  task automatic beat(input logic [SW-1:0] x, input logic [1:0] m, input logic inv,
                      output logic [SW-1:0] y, output logic v);
    in_valid = 1'b1; in_state = x; in_mode = m; in_inv = inv;
    @(posedge clk); @(negedge clk);
    y = out_state; v = out_valid;
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 valid", {255'b0, out_valid}, '0);
    check("R11 state", out_state, '0);
  endtask

  task automatic t_dir(input logic inv);
    logic [SW-1:0] y; logic v;
    for (int m = 0; m < 4; m++) begin
      logic [SW-1:0] x;
      x = pattern(8'(17*m + 3), 8'h05);
      beat(x, 2'(m), inv, y, v);
      check("R8 valid", {255'b0, v}, {255'b0, 1'b1});
      if (!inv) check(m == 2 ? "R5 R3 forward" : "R4 R3 R1 forward", y, model(x, 2'(m), 1'b0));
      else      check(m == 2 ? "R5 R6 inverse" : "R4 R6 R1 inverse", y, model(x, 2'(m), 1'b1));
    end
  endtask

  task automatic t_layout();
    // R2: only byte 19 (row 3, column 4) nonzero; 8-column forward moves it to byte 3
    logic [SW-1:0] x, e, y; logic v;
    x = '0; x[SW-1-8*19 -: 8] = 8'hA5;
    e = '0; e[SW-1-8*3 -: 8]  = 8'hA5;
    beat(x, 2'b10, 1'b0, y, v);
    check("R2 R5 byte position", y, e);
  endtask

  task automatic t_unused();
    logic [SW-1:0] y; logic v;
    beat({SW{1'b1}}, 2'b00, 1'b0, y, v);
    check("R7 4-col upper zero", y & {128'b0, {128{1'b1}}}, '0);
    beat({SW{1'b1}}, 2'b01, 1'b1, y, v);
    check("R7 6-col upper zero", y & {192'b0, {64{1'b1}}}, '0);
  endtask

  task automatic t_roundtrip();
    logic [SW-1:0] y, z; logic v;
    for (int m = 0; m < 3; m++) begin
      logic [SW-1:0] x;
      x = pattern(8'(m * 40 + 9), 8'h0B);
      beat(x, 2'(m), 1'b0, y, v);
      beat(y, 2'(m), 1'b1, z, v);
      check("R10 round trip", z, keep_cols(x, 2'(m)));
    end
  endtask

  task automatic t_hold();
    logic [SW-1:0] y, y2; logic v;
    beat(pattern(8'h30, 8'h03), 2'b10, 1'b1, y, v);
    in_state = pattern(8'hF0, 8'h11); in_mode = 2'b00; in_inv = 1'b0;
    repeat (3) @(negedge clk);
    y2 = out_state;
    check("R9 state held", y2, y);
    check("R8 R9 valid low", {255'b0, out_valid}, '0);
  endtask

  task automatic t_stream();
    logic [SW-1:0] xs [6];
    logic [1:0]    ms [6];
    logic          ds [6];
    for (int i = 0; i < 6; i++) begin
      xs[i] = pattern(8'(i * 29 + 1), 8'(i + 1));
      ms[i] = 2'(i % 3);
      ds[i] = i[0];
    end
    in_valid = 1'b1; in_state = xs[0]; in_mode = ms[0]; in_inv = ds[0];
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      check("R8 stream valid", {255'b0, out_valid}, {255'b0, 1'b1});
      check("R3 R6 stream result", out_state, model(xs[i], ms[i], ds[i]));
      if (i < 5) begin
        in_state = xs[i+1]; in_mode = ms[i+1]; in_inv = ds[i+1];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(posedge clk); @(negedge clk);
    check("R8 valid drops", {255'b0, out_valid}, '0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_inv = 1'b0;
    in_state = pattern(8'h55, 8'h01);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir(1'b0);
    t_dir(1'b1);
    t_layout();
    t_unused();
    t_roundtrip();
    t_hold();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule